// File: doc/BRIEF.md
# I2C Register Target Interface

This block lets an I2C controller read and write a small register array inside a sensor. It samples the bus clock and data lines through synchronisers running on a faster system clock. It recognises START, repeated START and STOP conditions, and answers one 7-bit device address. The six upper bits of that address are a build-time parameter (default 110100b). The lowest bit follows a strap input.

After a write-direction address, the first byte is a sub-address. Its low seven bits set a register pointer and its top bit switches on pointer auto-increment. Every later byte in that direction is written to the register the pointer selects. To read, the controller writes the sub-address, issues a repeated START and then sends the read-direction address. The block then shifts out the selected register MSB-first. It keeps doing so for as long as the controller acknowledges.

The register array is external. The block presents a 7-bit pointer together with one-cycle write and read strobes. Read data is taken back combinationally in the cycle of the read strobe.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset, and after any STOP, the block releases SDA and raises no write or read strobe until a new START.
- R2: The block acknowledges the first byte after a START when its upper seven bits are 110100 followed by the strap level, so D0h/D1h match with the strap low and D2h/D3h with the strap high. To acknowledge, it holds SDA low while SCL is high in the ninth clock.
- R3: When the address does not match, the block leaves SDA released and makes no register access until the next START or STOP.
- R4: The byte after a matched write address is acknowledged. Bits 6:0 of that byte load the register pointer and bit 7 enables auto-increment.
- R5: Each later written byte is acknowledged and gives exactly one single-cycle write strobe, carrying the pointer and the received byte.
- R6: With auto-increment on, the pointer advances by one after every transferred data byte, in both directions.
- R7: With auto-increment off, every data byte accesses the same register.
- R8: With auto-increment on, the pointer wraps from 7Fh to 00h.
- R9: After a read address, the block shifts out the pointed-to register MSB-first. SDA changes only while SCL is low.
- R10: During a read, an acknowledge from the controller starts the next byte. A not-acknowledge makes the block release SDA and stay silent until START or STOP.
- R11: A START or STOP inside a byte abandons that byte without a register write, and a START restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaPullLow | output | 1 | When high, the data line is driven low |
| addrStrap | input | 1 | Sets the device address LSb |
| regAddr | output | PTR_W | Register pointer to the external array |
| regWrEn | output | 1 | One-cycle write strobe |
| regWrData | output | 8 | Byte to write |
| regRdEn | output | 1 | One-cycle read strobe |
| regRdData | input | 8 | Register contents at regAddr |

## Verification
The bench tries addresses with each strap level, so a match on the fixed bits alone is not enough to pass. Burst writes and reads are run with the increment bit set and cleared, and one sub-address starts at 7Fh to exercise the wrap. Reads end once on an acknowledge and once on a not-acknowledge, which shows whether the bus is released. Partial bytes cut off by STOP or by a repeated START show whether a stray write is committed.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W    = 8;
  localparam int DEV_ADR_W = 7;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_SUB, ST_SUB_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_RDATA, ST_RDATA_ACK, ST_SKIP
  } tgtState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic rxBit;
    logic txBit;
    logic clrCnt;
    logic loadPtr;
    logic bumpPtr;
    logic loadTx;
    logic shiftTx;
    logic grabAck;
  } dpCtl_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2  // at least 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic [1:0] rawIn, lvl, prev;
  assign rawIn = {sdaIn, sclIn};

  for (genvar g = 0; g < 2; g++) begin : gLine
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[STAGES-2:0], rawIn[g]};
    end
    assign lvl[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prev <= '1;
    else       prev <= lvl;
  end

  assign sclLvl   = lvl[0];
  assign sdaLvl   = lvl[1];
  assign sclRise  = lvl[0] & ~prev[0];
  assign sclFall  = ~lvl[0] & prev[0];
  assign startDet = lvl[0] & prev[0] & ~lvl[1] & prev[1];
  assign stopDet  = lvl[0] & prev[0] & lvl[1] & ~prev[1];
endmodule

// File: rtl/i2c_tgt_dp.sv
module i2c_tgt_dp
  import i2c_tgt_pkg::*;
#(
  parameter int                 PTR_W  = 7,
  parameter logic [DEV_ADR_W-2:0] DEV_HI = 6'b110100
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              sdaLvl,
  input  logic              strap,
  input  logic [BYTE_W-1:0] regRdData,
  output logic              byteFull,
  output logic              addrMatch,
  output logic              rwBit,
  output logic              nackSeen,
  output logic              txMsb,
  output logic [PTR_W-1:0]  regAddr,
  output logic [BYTE_W-1:0] regWrData
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxShift, txShift;
  logic [PTR_W-1:0]  ptr;
  logic              autoInc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      byteFull <= 1'b0;
      rxShift  <= '0;
      txShift  <= '0;
      ptr      <= '0;
      autoInc  <= 1'b0;
      nackSeen <= 1'b0;
    end else begin
      if (ctl.clrCnt) begin
        bitCnt   <= '0;
        byteFull <= 1'b0;
      end else if (ctl.rxBit || ctl.txBit) begin
        bitCnt <= bitCnt + CNT_W'(1);
        if (bitCnt == CNT_W'(BYTE_W - 1)) byteFull <= 1'b1;
      end
      if (ctl.rxBit) rxShift <= {rxShift[BYTE_W-2:0], sdaLvl};
      if (ctl.loadTx)       txShift <= regRdData;
      else if (ctl.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b0};
      if (ctl.loadPtr) begin
        ptr     <= rxShift[PTR_W-1:0];
        autoInc <= rxShift[BYTE_W-1];
      end else if (ctl.bumpPtr && autoInc) begin
        ptr <= ptr + PTR_W'(1);
      end
      if (ctl.grabAck) nackSeen <= sdaLvl;
    end
  end

  assign addrMatch = (rxShift[BYTE_W-1:1] == {DEV_HI, strap});
  assign rwBit     = rxShift[0];
  assign txMsb     = txShift[BYTE_W-1];
  assign regAddr   = ptr;
  assign regWrData = rxShift;

  // R8: pointer wraps to zero
  assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.bumpPtr && autoInc && !ctl.loadPtr && ptr == '1) |=> (ptr == '0));
  // R7: pointer holds without auto-increment
  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.bumpPtr && !autoInc && !ctl.loadPtr) |=> $stable(ptr));
endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclLvl,
  input  logic   sclRise,
  input  logic   sclFall,
  input  logic   startDet,
  input  logic   stopDet,
  input  logic   byteFull,
  input  logic   addrMatch,
  input  logic   rwBit,
  input  logic   nackSeen,
  input  logic   txMsb,
  output dpCtl_t ctl,
  output logic   sdaPullLow,
  output logic   regWrEn,
  output logic   regRdEn
);
  tgtState_e state, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt     = state;
    ctl     = '0;
    regWrEn = 1'b0;
    regRdEn = 1'b0;
    if (startDet) begin
      nxt        = ST_ADDR;
      ctl.clrCnt = 1'b1;
    end else if (stopDet) begin
      nxt        = ST_IDLE;
      ctl.clrCnt = 1'b1;
    end else begin
      if (sclRise) begin
        case (state)
          ST_ADDR, ST_SUB, ST_WDATA: ctl.rxBit   = 1'b1;
          ST_RDATA:                  ctl.txBit   = 1'b1;
          ST_RDATA_ACK:              ctl.grabAck = 1'b1;
          default: ;
        endcase
      end
      if (sclFall) begin
        case (state)
          ST_ADDR: if (byteFull) begin
            nxt        = addrMatch ? ST_ADDR_ACK : ST_SKIP;
            ctl.clrCnt = 1'b1;
          end
          ST_ADDR_ACK: begin
            ctl.clrCnt = 1'b1;
            if (rwBit) begin
              nxt        = ST_RDATA;
              ctl.loadTx = 1'b1;
              regRdEn    = 1'b1;
            end else begin
              nxt = ST_SUB;
            end
          end
          ST_SUB: if (byteFull) begin
            nxt         = ST_SUB_ACK;
            ctl.loadPtr = 1'b1;
            ctl.clrCnt  = 1'b1;
          end
          ST_SUB_ACK: begin
            nxt        = ST_WDATA;
            ctl.clrCnt = 1'b1;
          end
          ST_WDATA: if (byteFull) begin
            nxt         = ST_WDATA_ACK;
            regWrEn     = 1'b1;
            ctl.bumpPtr = 1'b1;
            ctl.clrCnt  = 1'b1;
          end
          ST_WDATA_ACK: begin
            nxt        = ST_WDATA;
            ctl.clrCnt = 1'b1;
          end
          ST_RDATA: begin
            if (byteFull) begin
              nxt         = ST_RDATA_ACK;
              ctl.bumpPtr = 1'b1;
              ctl.clrCnt  = 1'b1;
            end else begin
              ctl.shiftTx = 1'b1;
            end
          end
          ST_RDATA_ACK: begin
            ctl.clrCnt = 1'b1;
            if (nackSeen) begin
              nxt = ST_SKIP;
            end else begin
              nxt        = ST_RDATA;
              ctl.loadTx = 1'b1;
              regRdEn    = 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (state)
      ST_ADDR_ACK, ST_SUB_ACK, ST_WDATA_ACK: sdaPullLow = 1'b1;
      ST_RDATA:                              sdaPullLow = ~txMsb;
      default:                               sdaPullLow = 1'b0;
    endcase
  end

  // R9: data line only moves while the clock is low
  assert_sda_moves_low_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> !sclLvl);
  // R5: write strobe lasts one cycle
  assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);
  // R11: START restarts address reception
  assert_start_addr_R11: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (state == ST_ADDR));
  // R1: STOP releases the bus
  assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (!sdaPullLow && !regWrEn && !regRdEn));
  // R3: a skipped transfer stays silent
  assert_skip_silent_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SKIP) |-> (!sdaPullLow && !regWrEn && !regRdEn));
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter int                   PTR_W       = 7,
  parameter int                   SYNC_STAGES = 2,
  parameter logic [DEV_ADR_W-2:0] DEV_HI      = 6'b110100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullLow,
  input  logic              addrStrap,
  output logic [PTR_W-1:0]  regAddr,
  output logic              regWrEn,
  output logic [BYTE_W-1:0] regWrData,
  output logic              regRdEn,
  input  logic [BYTE_W-1:0] regRdData
);
  logic   sclLvl, sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic   byteFull, addrMatch, rwBit, nackSeen, txMsb;
  dpCtl_t ctl;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2c_tgt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet),
    .byteFull(byteFull), .addrMatch(addrMatch), .rwBit(rwBit),
    .nackSeen(nackSeen), .txMsb(txMsb), .ctl(ctl),
    .sdaPullLow(sdaPullLow), .regWrEn(regWrEn), .regRdEn(regRdEn)
  );

  i2c_tgt_dp #(.PTR_W(PTR_W), .DEV_HI(DEV_HI)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sdaLvl(sdaLvl), .strap(addrStrap),
    .regRdData(regRdData), .byteFull(byteFull), .addrMatch(addrMatch),
    .rwBit(rwBit), .nackSeen(nackSeen), .txMsb(txMsb),
    .regAddr(regAddr), .regWrData(regWrData)
  );
endmodule

// File: tb/i2c_reg_target_bench.sv
module i2c_reg_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;  // system clocks per quarter bit

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclDrv = 1'b1, sdaDrv = 1'b1, strap = 1'b0;
  logic sdaPullLow, regWrEn, regRdEn;
  logic [6:0] regAddr;
  logic [7:0] regWrData, regRdData;
  logic [7:0] regs [128];
  logic sdaLine;
  int checkCnt = 0, failCnt = 0;
  bit done = 1'b0;
  logic [14:0] expQ [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaLine   = sdaDrv & ~sdaPullLow;
  assign regRdData = regs[regAddr];

  i2c_reg_target u_i2c_reg_target (
    .clk(clk), .rstN(rstN), .sclIn(sclDrv), .sdaIn(sdaLine),
    .sdaPullLow(sdaPullLow), .addrStrap(strap), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .regRdData(regRdData)
  );

  // external register array
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 128; i++) regs[i] <= 8'(i) ^ 8'h5A;
    end else if (regWrEn) begin
      regs[regAddr] <= regWrData;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for write strobes
  always @(negedge clk) begin
    if (rstN && regWrEn) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R3 R11 unexpected write", {1'b0, regAddr, regWrData}, 16'h0);
      end else begin
        logic [14:0] item;
        item = expQ.pop_front();
        check({regAddr, regWrData} == item, "R5 R6 R7 R8 write scoreboard",
              {1'b0, regAddr, regWrData}, {1'b0, item});
      end
    end
  end

  task automatic waitQ();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic sendBit(input logic b);
    sdaDrv = b; waitQ();
    sclDrv = 1'b1; waitQ(); waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic busStart();
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaDrv = 1'b0; waitQ();
    sclDrv = 1'b1; waitQ();
    sdaDrv = 1'b1; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    sdaDrv = 1'b1; waitQ();
    sclDrv = 1'b1; waitQ();
    acked = ~sdaLine; waitQ();
    sclDrv = 1'b0; waitQ();
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      sdaDrv = 1'b1; waitQ();
      sclDrv = 1'b1; waitQ();
      v[i] = sdaLine; waitQ();
      sclDrv = 1'b0; waitQ();
    end
    sendBit(~ackIt);
  endtask

  task automatic pushWr(input logic [6:0] a, input logic [7:0] d);
    expQ.push_back({a, d});
  endtask

  initial begin
    logic ack;
    logic [7:0] rd;
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    waitQ();
    check(!sdaPullLow && !regWrEn && !regRdEn, "R1 reset idle",
          {13'b0, sdaPullLow, regWrEn, regRdEn}, 16'h0);

    // single write, strap low
    busStart();
    writeByte(8'hD0, ack); check(ack, "R2 ack D0 strap low", ack, 1);
    writeByte(8'h10, ack); check(ack, "R4 ack sub", ack, 1);
    pushWr(7'h10, 8'hA5);
    writeByte(8'hA5, ack); check(ack, "R5 ack data", ack, 1);
    busStop();
    check(!sdaPullLow, "R1 released after stop", sdaPullLow, 0);

    // mismatching address ignored
    busStart();
    writeByte(8'hD2, ack); check(!ack, "R3 nack D2 strap low", ack, 0);
    writeByte(8'h10, ack); check(!ack, "R3 ignored sub", ack, 0);
    writeByte(8'h33, ack); check(!ack, "R3 ignored data", ack, 0);
    busStop();

    // burst write with auto-increment, strap high
    strap = 1'b1;
    busStart();
    writeByte(8'hD2, ack); check(ack, "R2 ack D2 strap high", ack, 1);
    writeByte(8'h90, ack);
    pushWr(7'h10, 8'h11); pushWr(7'h11, 8'h22); pushWr(7'h12, 8'h33);
    writeByte(8'h11, ack); writeByte(8'h22, ack); writeByte(8'h33, ack);
    check(ack, "R6 ack burst", ack, 1);
    busStop();

    busStart();
    writeByte(8'hD0, ack); check(!ack, "R3 nack D0 strap high", ack, 0);
    busStop();

    // fixed pointer (R7)
    busStart();
    writeByte(8'hD2, ack); writeByte(8'h20, ack);
    pushWr(7'h20, 8'h44); pushWr(7'h20, 8'h55);
    writeByte(8'h44, ack); writeByte(8'h55, ack);
    busStop();

    // wrap (R8)
    busStart();
    writeByte(8'hD2, ack); writeByte(8'hFF, ack);
    pushWr(7'h7F, 8'h66); pushWr(7'h00, 8'h77);
    writeByte(8'h66, ack); writeByte(8'h77, ack);
    busStop();

    // burst read with auto-increment (R9, R10)
    busStart();
    writeByte(8'hD2, ack); writeByte(8'h91, ack);
    busStart();
    writeByte(8'hD3, ack); check(ack, "R2 ack D3 read", ack, 1);
    readByte(1'b1, rd); check(rd == 8'h22, "R9 read first", rd, 8'h22);
    readByte(1'b1, rd); check(rd == 8'h33, "R6 read incremented", rd, 8'h33);
    readByte(1'b0, rd); check(rd == 8'h49, "R10 read after ack", rd, 8'h49);
    check(!sdaPullLow, "R10 released after nack", sdaPullLow, 0);
    sdaDrv = 1'b1; waitQ(); sclDrv = 1'b1; waitQ();
    check(sdaLine, "R10 line high after nack", sdaLine, 1);
    sclDrv = 1'b0; waitQ();
    busStop();

    // aborted bytes (R11)
    busStart();
    writeByte(8'hD2, ack); writeByte(8'h30, ack);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
    busStop();
    busStart();
    writeByte(8'hD2, ack); writeByte(8'h40, ack);
    sendBit(1'b1); sendBit(1'b1); sendBit(1'b0);
    busStart();
    writeByte(8'hD2, ack); check(ack, "R11 ack after restart", ack, 1);
    writeByte(8'h41, ack);
    pushWr(7'h41, 8'h99);
    writeByte(8'h99, ack);
    busStop();

    // repeated read of one register (R7)
    busStart();
    writeByte(8'hD2, ack); writeByte(8'h12, ack);
    busStart();
    writeByte(8'hD3, ack);
    readByte(1'b1, rd); check(rd == 8'h33, "R7 read fixed first", rd, 8'h33);
    readByte(1'b0, rd); check(rd == 8'h33, "R7 read fixed second", rd, 8'h33);
    busStop();

    // read back the restarted write (R11)
    busStart();
    writeByte(8'hD2, ack); writeByte(8'h41, ack);
    busStart();
    writeByte(8'hD3, ack);
    readByte(1'b0, rd); check(rd == 8'h99, "R11 data after restart", rd, 8'h99);
    busStop();

    waitQ();
    check(expQ.size() == 0, "R5 all writes seen", 16'(expQ.size()), 16'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end
endmodule